// File: doc/BRIEF.md
# Weighted Joint Block Mode Selector

This block settles the prediction mode for one 16x16 luma macroblock in the second view of a stereo encoder. It receives three column streams in lockstep: the current block, the best motion-compensated prediction and the best disparity-compensated prediction. From the two predictions it builds up to eight blended predictions, each a fixed mix in eighths made with shifts and adders only. It keeps a running sum of absolute differences (SAD) for every candidate against the current block.

A start pulse opens a macroblock. It clears the sums and captures the blend weight table and the slot enable mask. Sixteen columns then follow, one per cycle, each carrying sixteen pixels. After the last column the block compares the motion SAD, the disparity SAD and the SADs of the enabled blends. It then reports the winning mode and its SAD with a one-cycle done pulse. The motion and disparity searches that produce the two predictions are outside this block.

Top module: `jb_mode_select`

## Requirements
- R1: After reset is released, done_o, mode_o and sad_o are all zero until a macroblock completes.
- R2: A start pulse followed by exactly 16 accepted columns produces one done_o pulse, lasting one cycle. It is high in the cycle after the clock edge that follows the edge sampling the last column.
- R3: The mode code is 0 for motion-only, 1 for disparity-only and 2+k for blend slot k. sad_o is the 16-column SAD of the reported candidate.
- R4: Blend slot k takes weight w, in eighths applied to the disparity pixel, from slot_wgt_i[4k+3:4k]. Its pixel is (w*D + (8-w)*M + 4) >> 3.
- R5: A slot weight field above 8 acts as 8, so the slot behaves like disparity-only prediction.
- R6: Slot k takes part only when slot_en_i[k] is 1. A disabled slot is never reported.
- R7: Among equal SADs the lowest mode code wins.
- R8: Weights and enables are captured at the start pulse. Changing them while columns are arriving has no effect on the result.
- R9: A start pulse in the middle of a macroblock discards the partial sums and begins a new one. A column presented in the same cycle as start is not accumulated.
- R10: Columns presented when no macroblock is open are ignored and produce no done_o.
- R11: SADs up to the full-scale 16*16*255 = 65280 are reported without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a macroblock, clears sums, captures weights and enables |
| col_vld_i | input | 1 | A column is present on the three column inputs |
| cur_col_i | input | 128 | Current block column, row r at bits [8r+7:8r] |
| mc_col_i | input | 128 | Motion-compensated column, same layout |
| dc_col_i | input | 128 | Disparity-compensated column, same layout |
| slot_wgt_i | input | 32 | Eight 4-bit blend weights in eighths |
| slot_en_i | input | 8 | Enable per blend slot |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| mode_o | output | 4 | Winning mode code |
| sad_o | output | 16 | SAD of the winning mode |

## Verification
One target is a current block placed exactly on a rounded blend, where an error in the rounding offset or the shift-add weighting moves the zero-SAD result to a neighbouring slot. Another is a block made of equal candidates, where a wrong tie order reports a blend or disparity instead of motion. A weight of 15 is chosen so that an unclamped slot would extrapolate to a zero SAD. The remaining runs disable slots, change the table after the start pulse, restart in the middle of a macroblock, send columns while idle and drive full-scale data. A design that gets these wrong selects a masked slot, uses the late table, merges two macroblocks, pulses done without a start, or wraps its sums.

// File: rtl/jb_pkg.sv
package jb_pkg;
  localparam int unsigned MODE_MC         = 0;
  localparam int unsigned MODE_DC         = 1;
  localparam int unsigned MODE_BLEND_BASE = 2;
endpackage

// File: rtl/jb_blend_px.sv
module jb_blend_px #(
  parameter  int PIX_W    = 8,
  parameter  int WGT_FRAC = 3,
  localparam int WGT_W    = WGT_FRAC + 1
) (
  input  logic [PIX_W-1:0] mc_i,
  input  logic [PIX_W-1:0] dc_i,
  input  logic [WGT_W-1:0] wgt_i,
  output logic [PIX_W-1:0] px_o
);
  localparam int SW = PIX_W + WGT_W + 2;

  logic signed [SW-1:0] diff_s;
  logic signed [SW-1:0] acc_s;

  // 8*M + w*(D-M) + half, built as a shift-add over the weight bits
  always_comb begin
    diff_s = SW'($signed({1'b0, dc_i})) - SW'($signed({1'b0, mc_i}));
    acc_s  = SW'($signed({1'b0, mc_i})) <<< WGT_FRAC;
    acc_s  = acc_s + SW'(1 << (WGT_FRAC - 1));
    for (int k = 0; k < WGT_W; k++) begin
      if (wgt_i[k]) acc_s = acc_s + (diff_s <<< k);
    end
  end

  assign px_o = acc_s[WGT_FRAC +: PIX_W];

  logic unused_acc;
  assign unused_acc = ^{acc_s[SW-1:WGT_FRAC+PIX_W], acc_s[WGT_FRAC-1:0]};
endmodule

// File: rtl/jb_col_sad.sv
module jb_col_sad #(
  parameter  int PIX_W  = 8,
  parameter  int ROWS   = 16,
  localparam int CSAD_W = PIX_W + $clog2(ROWS)
) (
  input  logic [ROWS*PIX_W-1:0] cur_i,
  input  logic [ROWS*PIX_W-1:0] pred_i,
  output logic [CSAD_W-1:0]     sad_o
);
  logic [PIX_W-1:0] ad [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [PIX_W-1:0] c_px, p_px;
    assign c_px  = cur_i[r*PIX_W +: PIX_W];
    assign p_px  = pred_i[r*PIX_W +: PIX_W];
    assign ad[r] = (c_px > p_px) ? (c_px - p_px) : (p_px - c_px);
  end

  always_comb begin
    sad_o = '0;
    for (int r = 0; r < ROWS; r++) sad_o = sad_o + CSAD_W'(ad[r]);
  end
endmodule

// File: rtl/jb_min_select.sv
module jb_min_select #(
  parameter  int N_CAND = 10,
  parameter  int SAD_W  = 16,
  localparam int MODE_W = $clog2(N_CAND)
) (
  input  logic [N_CAND*SAD_W-1:0] sad_i,
  input  logic [N_CAND-1:0]       en_i,
  output logic [MODE_W-1:0]       mode_o,
  output logic [SAD_W-1:0]        sad_o
);
  // strict less-than scan: earlier candidate keeps a tie
  always_comb begin
    mode_o = '0;
    sad_o  = sad_i[0 +: SAD_W];
    for (int c = 1; c < N_CAND; c++) begin
      if (en_i[c] && (sad_i[c*SAD_W +: SAD_W] < sad_o)) begin
        mode_o = MODE_W'(c);
        sad_o  = sad_i[c*SAD_W +: SAD_W];
      end
    end
  end

  logic unused_en0;
  assign unused_en0 = en_i[0];
endmodule

// File: rtl/jb_mode_select.sv
module jb_mode_select
  import jb_pkg::*;
#(
  parameter  int PIX_W    = 8,
  parameter  int ROWS     = 16,
  parameter  int COLS     = 16,
  parameter  int N_SLOT   = 8,
  parameter  int WGT_FRAC = 3,
  localparam int WGT_W    = WGT_FRAC + 1,
  localparam int N_CAND   = N_SLOT + MODE_BLEND_BASE,
  localparam int MODE_W   = $clog2(N_CAND),
  localparam int CSAD_W   = PIX_W + $clog2(ROWS),
  localparam int SAD_W    = CSAD_W + $clog2(COLS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    col_vld_i,
  input  logic [ROWS*PIX_W-1:0]   cur_col_i,
  input  logic [ROWS*PIX_W-1:0]   mc_col_i,
  input  logic [ROWS*PIX_W-1:0]   dc_col_i,
  input  logic [N_SLOT*WGT_W-1:0] slot_wgt_i,
  input  logic [N_SLOT-1:0]       slot_en_i,
  output logic                    done_o,
  output logic [MODE_W-1:0]       mode_o,
  output logic [SAD_W-1:0]        sad_o
);
  localparam int CNT_W = $clog2(COLS + 1);
  localparam logic [WGT_W-1:0] W_MAX = WGT_W'(1 << WGT_FRAC);

  logic [WGT_W-1:0]  wgt_sat [N_SLOT];
  logic [WGT_W-1:0]  wgt_q   [N_SLOT];
  logic [N_SLOT-1:0] en_q;
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fin_q;
  logic              done_q;
  logic [MODE_W-1:0] mode_q;
  logic [SAD_W-1:0]  sad_q;

  logic [N_SLOT-1:0][ROWS*PIX_W-1:0] blend_col;
  logic [N_CAND-1:0][CSAD_W-1:0]     col_sad;
  logic [N_CAND-1:0][SAD_W-1:0]      acc_q;
  logic [N_CAND-1:0]                 cand_en;
  logic [MODE_W-1:0]                 sel_mode;
  logic [SAD_W-1:0]                  sel_sad;
  logic                              accept;
  logic                              last_col;

  always_comb begin
    for (int s = 0; s < N_SLOT; s++) begin
      wgt_sat[s] = (slot_wgt_i[s*WGT_W +: WGT_W] > W_MAX) ? W_MAX
                                                          : slot_wgt_i[s*WGT_W +: WGT_W];
    end
  end

  // blend array: one pixel unit per slot and row
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    for (genvar r = 0; r < ROWS; r++) begin : g_px
      jb_blend_px #(.PIX_W(PIX_W), .WGT_FRAC(WGT_FRAC)) u_px (
        .mc_i (mc_col_i[r*PIX_W +: PIX_W]),
        .dc_i (dc_col_i[r*PIX_W +: PIX_W]),
        .wgt_i(wgt_q[s]),
        .px_o (blend_col[s][r*PIX_W +: PIX_W])
      );
    end
  end

  for (genvar c = 0; c < N_CAND; c++) begin : g_cand
    logic [ROWS*PIX_W-1:0] pred;
    if (c == MODE_MC) begin : g_mc
      assign pred = mc_col_i;
    end else if (c == MODE_DC) begin : g_dc
      assign pred = dc_col_i;
    end else begin : g_bl
      assign pred = blend_col[c-MODE_BLEND_BASE];
    end
    jb_col_sad #(.PIX_W(PIX_W), .ROWS(ROWS)) u_sad (
      .cur_i (cur_col_i),
      .pred_i(pred),
      .sad_o (col_sad[c])
    );
  end

  assign cand_en  = {en_q, 2'b11};
  assign accept   = col_vld_i & active_q & ~start_i;
  assign last_col = (cnt_q == CNT_W'(COLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      fin_q    <= 1'b0;
      acc_q    <= '0;
      en_q     <= '0;
      for (int s = 0; s < N_SLOT; s++) wgt_q[s] <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        acc_q    <= '0;
        en_q     <= slot_en_i;
        for (int s = 0; s < N_SLOT; s++) wgt_q[s] <= wgt_sat[s];
      end else if (accept) begin
        for (int c = 0; c < N_CAND; c++) acc_q[c] <= acc_q[c] + SAD_W'(col_sad[c]);
        cnt_q <= cnt_q + 1'b1;
        if (last_col) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end
      end
    end
  end

  jb_min_select #(.N_CAND(N_CAND), .SAD_W(SAD_W)) u_min (
    .sad_i (acc_q),
    .en_i  (cand_en),
    .mode_o(sel_mode),
    .sad_o (sel_sad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mode_q <= '0;
      sad_q  <= '0;
    end else begin
      done_q <= fin_q;
      if (fin_q) begin
        mode_q <= sel_mode;
        sad_q  <= sel_sad;
      end
    end
  end

  assign done_o = done_q;
  assign mode_o = mode_q;
  assign sad_o  = sad_q;

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_fin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(fin_q));
  assert_sel_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> cand_en[sel_mode]);
  assert_sel_not_above_mc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> (sel_sad <= acc_q[MODE_MC]));
  assert_fin_closes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> !active_q);
  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(COLS));
endmodule

// File: tb/jb_mode_select_tb.sv
module jb_mode_select_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, vld;
  logic [127:0] cur_c, mc_c, dc_c;
  logic [31:0]  wgt;
  logic [7:0]   en;
  logic         done;
  logic [3:0]   mode;
  logic [15:0]  sad;

  localparam logic [31:0] DEF_WT = 32'h0765_4321;
  localparam logic [7:0]  DEF_EN = 8'h7F;

  jb_mode_select u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_vld_i(vld),
    .cur_col_i(cur_c), .mc_col_i(mc_c), .dc_col_i(dc_c),
    .slot_wgt_i(wgt), .slot_en_i(en),
    .done_o(done), .mode_o(mode), .sad_o(sad)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]  mode;
    logic [15:0] sad;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0, cyc = 0, n_push = 0, n_done = 0;
  bit finished = 0;
  logic [7:0] cur_a [16][16];
  logic [7:0] mc_a  [16][16];
  logic [7:0] dc_a  [16][16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (q.size() == 0) begin
        check(0, "R10 done without open block", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(mode == e.mode, {e.tag, " mode"}, mode, e.mode);
        check(sad == e.sad, {e.tag, " sad"}, sad, e.sad);
        check(cyc == e.cyc, "R2 done cycle", cyc, e.cyc);
      end
    end
  end

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic calc(input logic [31:0] wt, input logic [7:0] m_en,
                      output logic [3:0] o_mode, output logic [15:0] o_sad);
    int s[10];
    int best;
    for (int c = 0; c < 10; c++) s[c] = 0;
    for (int col = 0; col < 16; col++) begin
      for (int r = 0; r < 16; r++) begin
        int m, d, x;
        m = mc_a[col][r]; d = dc_a[col][r]; x = cur_a[col][r];
        s[0] += iabs(x - m);
        s[1] += iabs(x - d);
        for (int k = 0; k < 8; k++) begin
          int w, b;
          w = wt[4*k +: 4];
          if (w > 8) w = 8;
          b = (w * d + (8 - w) * m + 4) >> 3;
          s[2+k] += iabs(x - b);
        end
      end
    end
    o_mode = 0; best = s[0];
    for (int c = 1; c < 10; c++) begin
      if ((c < 2 || m_en[c-2]) && s[c] < best) begin
        best = s[c]; o_mode = 4'(c);
      end
    end
    o_sad = 16'(best);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [127:0] pack(input int which, input int col);
    logic [127:0] v;
    for (int r = 0; r < 16; r++) begin
      case (which)
        0:       v[r*8 +: 8] = cur_a[col][r];
        1:       v[r*8 +: 8] = mc_a[col][r];
        default: v[r*8 +: 8] = dc_a[col][r];
      endcase
    end
    return v;
  endfunction

  task automatic start_blk(input logic [31:0] wt, input logic [7:0] m_en);
    start = 1; wgt = wt; en = m_en;
    step();
    start = 0;
  endtask

  task automatic send_col(input int col);
    vld = 1; cur_c = pack(0, col); mc_c = pack(1, col); dc_c = pack(2, col);
    step();
    vld = 0;
  endtask

  task automatic push(input logic [3:0] m, input logic [15:0] s, input string tag);
    exp_t e;
    e.mode = m; e.sad = s; e.cyc = cyc + 1; e.tag = tag;
    q.push_back(e);
    n_push++;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic run_block(input logic [31:0] wt, input logic [7:0] m_en, input string tag);
    logic [3:0] em; logic [15:0] es;
    calc(wt, m_en, em, es);
    start_blk(wt, m_en);
    for (int c = 0; c < 16; c++) send_col(c);
    push(em, es, tag);
    idle(4);
  endtask

  task automatic fill_rand();
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) begin
        cur_a[c][r] = 8'($urandom);
        mc_a[c][r]  = 8'($urandom);
        dc_a[c][r]  = 8'($urandom);
      end
  endtask

  // current block near a blend of the two predictions, with noise
  task automatic fill_near(input int w);
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) begin
        int m, d, b;
        m = $urandom_range(0, 255); d = $urandom_range(0, 255);
        b = (w * d + (8 - w) * m + 4) >> 3;
        b = b + $urandom_range(0, 2) - 1;
        if (b < 0) b = 0;
        if (b > 255) b = 255;
        mc_a[c][r] = 8'(m); dc_a[c][r] = 8'(d); cur_a[c][r] = 8'(b);
      end
  endtask

  task automatic fill_const(input int m, input int d, input int x);
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) begin
        mc_a[c][r] = 8'(m); dc_a[c][r] = 8'(d); cur_a[c][r] = 8'(x);
      end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] em; logic [15:0] es;
    rst_n = 0; start = 0; vld = 0; cur_c = '0; mc_c = '0; dc_c = '0;
    wgt = DEF_WT; en = DEF_EN;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2);
    @(negedge clk);
    check(done == 0 && mode == 0 && sad == 0, "R1 reset outputs", {done, mode, sad}, 0);
    step();

    // R3 R7: current equals motion, disparity differs
    fill_const(50, 90, 50);
    run_block(DEF_WT, DEF_EN, "R3 motion exact");
    // R3: current equals disparity
    fill_const(50, 90, 90);
    run_block(DEF_WT, DEF_EN, "R3 disparity exact");
    // R4: exact blend w=5 -> slot 4, mode 6, sad 0
    fill_const(40, 200, 140);
    run_block(DEF_WT, DEF_EN, "R4 blend w5 exact");
    // R7: all equal -> motion wins
    fill_const(77, 77, 77);
    run_block(DEF_WT, DEF_EN, "R7 all equal");
    // R7: predictions equal, current differs -> every SAD equal, motion
    fill_const(10, 10, 30);
    run_block(DEF_WT, DEF_EN, "R7 equal predictions");
    // R4 random and near-blend patterns
    for (int i = 0; i < 4; i++) begin
      fill_rand();
      run_block(DEF_WT, DEF_EN, "R4 random");
    end
    for (int w = 1; w < 8; w += 2) begin
      fill_near(w);
      run_block(DEF_WT, DEF_EN, "R4 near blend");
    end
    // R6: slot 7 set to w=4 but disabled, other slots w=1
    fill_const(40, 200, 120);
    run_block(32'h4111_1111, 8'h7F, "R6 disabled slot");
    fill_near(3);
    run_block(DEF_WT, 8'h00, "R6 all slots off");
    // R5: weight 15 clamped to 8; unclamped would hit 115 exactly
    fill_const(100, 108, 115);
    run_block(32'h0000_000F, 8'h01, "R5 weight clamp");
    // R11: full-scale SAD
    fill_const(0, 0, 255);
    run_block(DEF_WT, DEF_EN, "R11 full scale");

    // R8: table changed after start
    fill_const(40, 200, 100);
    calc(DEF_WT, DEF_EN, em, es);
    start_blk(DEF_WT, DEF_EN);
    for (int c = 0; c < 16; c++) begin
      if (c == 1) begin wgt = 32'h8888_8888; en = 8'h00; end
      send_col(c);
    end
    push(em, es, "R8 late table change");
    idle(4);

    // R9: restart mid-block, with a column alongside the second start
    fill_rand();
    start_blk(DEF_WT, DEF_EN);
    for (int c = 0; c < 5; c++) send_col(c);
    fill_near(6);
    calc(DEF_WT, DEF_EN, em, es);
    start = 1; vld = 1; cur_c = '1; mc_c = '0; dc_c = '0;
    step();
    start = 0; vld = 0;
    for (int c = 0; c < 16; c++) send_col(c);
    push(em, es, "R9 restart");
    idle(4);

    // R10: columns with no open block
    fill_rand();
    for (int c = 0; c < 16; c++) send_col(c);
    idle(6);
    check(n_done == n_push, "R10 idle columns", n_done, n_push);
    fill_near(2);
    run_block(DEF_WT, DEF_EN, "R10 after idle");

    idle(4);
    check(q.size() == 0, "R2 pending results", q.size(), 0);
    check(n_done == n_push, "R2 done count", n_done, n_push);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule